// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block collects the completion events of sixteen DMA channels and drives a single interrupt request line. The channels form two groups of eight: a general-purpose group (channel numbers 0 to 7) and a peripheral-bound group (channel numbers 8 to 15). Each channel raises a one-cycle pulse when half of its transfer is done and another pulse when all of it is done. Each pulse sets a sticky bit in a 32-bit pending register.

Software reaches two 32-bit registers through a simple register port: a mask register and the pending register. A pending bit is cleared by writing a one to it. The interrupt line is asserted while any pending bit is set and its mask bit is also set. A driver unmasks only the completion bits it cares about, services the interrupt, and acknowledges it by writing the value it read back to the pending register.

Top module: `dma_irq_agg`

## Requirements
- R1: After a synchronous active-low reset, the mask register (offset 0x00) and the pending register (offset 0x04) both read zero, and `irq` is low.
- R2: For a channel in group g (0 = channel numbers 0..7, 1 = channel numbers 8..15) with index i within its group, a completion pulse sets pending bit g*16 + 2*i + 1 and a half-way pulse sets bit g*16 + 2*i. All completion bits therefore lie under mask 0xAAAAAAAA.
- R3: A pending bit stays set after its pulse ends, until software clears it.
- R4: A write to offset 0x04 clears exactly the bits written as one and leaves the other bits unchanged. Writing 0xFFFFFFFF clears every bit.
- R5: If an event pulse and a clearing write hit the same bit in the same cycle, the bit is left set.
- R6: A pending bit sets on its event whether or not its mask bit is set.
- R7: `irq` is the registered OR of (pending AND mask). It rises one clock after an unmasked bit becomes pending, and it is low while the mask register is zero.
- R8: A write to offset 0x00 stores all 32 data bits in the mask register, and a read returns that value.
- R9: A write to any other offset changes neither register, and a read of any other offset returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | 8 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ch_half | input | 16 | Half-way event pulses, one per channel |
| ch_done | input | 16 | Completion event pulses, one per channel |
| irq | output | 1 | Interrupt request, registered |

## Verification
Two functions can act on one pending bit in the same cycle: a channel's event pulse setting it, and a clearing write from software. The bench first makes a bit pending. It then, on one clock edge, pulses the same channel again and writes a clear mask that covers that bit and a second pending bit. Afterwards the first bit must still read as set while the second reads as clear, which shows that the set took priority and that the clear still reached the other bit.

// File: rtl/dma_irq_pkg.sv
`timescale 1ns/1ps
// Shared constants for the DMA interrupt aggregator.
// Assumes a 32-bit register port and two channel groups.
package dma_irq_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 8;
    localparam int GROUPS    = 2;
    localparam int CH_PER_GRP = 8;
    localparam logic [ADDR_W-1:0] OFS_MASK = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_PEND = 8'h04;
endpackage

// File: rtl/dma_irq_evmap.sv
`timescale 1ns/1ps
// Maps per-channel event pulses onto the pending bit layout.
// Group g, index i: half event -> bit g*2*CPG + 2i, done event -> the next bit.
// Assumes 2*GROUPS*CPG <= DW; unused upper bits stay zero.
module dma_irq_evmap #(
    parameter int GROUPS = 2,
    parameter int CPG    = 8,
    parameter int DW     = 32,
    localparam int NCH   = GROUPS * CPG
) (
    input  logic [NCH-1:0] half_pulse,
    input  logic [NCH-1:0] done_pulse,
    output logic [DW-1:0]  set_vec
);
    generate
        for (genvar g = 0; g < GROUPS; g++) begin : g_grp
            for (genvar i = 0; i < CPG; i++) begin : g_ch
                // interleave the two events of one channel on adjacent bits
                assign set_vec[g*2*CPG + 2*i]     = half_pulse[g*CPG + i];
                assign set_vec[g*2*CPG + 2*i + 1] = done_pulse[g*CPG + i];
            end
        end
        if (DW > 2*NCH) begin : g_pad
            assign set_vec[DW-1:2*NCH] = '0;
        end
    endgenerate
endmodule

// File: rtl/dma_irq_pend.sv
`timescale 1ns/1ps
// Sticky pending register with write-one-to-clear.
// A set in the same cycle as a clear of the same bit wins.
// Assumes set_vec and clr_vec are synchronous to clk.
module dma_irq_pend #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] set_vec,
    input  logic [DW-1:0] clr_vec,
    output logic [DW-1:0] pend_q
);
    // hold, clear, then set with priority
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_vec) | set_vec;
    end

    // R3: bits not being cleared remain set
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~clr_vec) != '0) |=> ((pend_q & $past(pend_q & ~clr_vec)) == $past(pend_q & ~clr_vec)));
    // R4: a clear without a simultaneous set empties the bit
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_vec & ~set_vec) != '0) |=> ((pend_q & $past(clr_vec & ~set_vec)) == '0));
    // R5: an event always lands, even against a clear
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)));
endmodule

// File: rtl/dma_irq_gen.sv
`timescale 1ns/1ps
// Registered interrupt request: OR of pending bits under mask.
// Assumes both vectors come straight from registers.
module dma_irq_gen #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] pend,
    input  logic [DW-1:0] mask,
    output logic          irq_q
);
    // one flop after the reduction to keep the output glitch-free
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(pend & mask);
    end

    // R7: all-zero mask silences the line next cycle
    p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |=> !irq_q);
    // R7: an unmasked pending bit raises the line next cycle
    p_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & mask) != '0) |=> irq_q);
endmodule

// File: rtl/dma_irq_agg.sv
`timescale 1ns/1ps
// DMA interrupt aggregator top: register port, mask register,
// event mapping, pending register and interrupt generation.
// Assumes single-cycle write strobes and pulse-shaped channel events.
module dma_irq_agg
    import dma_irq_pkg::*;
#(
    parameter int NCH = GROUPS * CH_PER_GRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NCH-1:0]    ch_half,
    input  logic [NCH-1:0]    ch_done,
    output logic              irq
);
    logic [DATA_W-1:0] mask_q;
    logic [DATA_W-1:0] pend_q;
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] clr_vec;
    logic              wr_mask;
    logic              wr_pend;

    // address decode of the write strobe
    always_comb begin
        wr_mask = reg_wr && (reg_addr == OFS_MASK);
        wr_pend = reg_wr && (reg_addr == OFS_PEND);
        clr_vec = wr_pend ? reg_wdata : '0;
    end

    // mask register
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (wr_mask) mask_q <= reg_wdata;
    end

    // read multiplexer, zero for unmapped offsets
    always_comb begin
        unique case (reg_addr)
            OFS_MASK: reg_rdata = mask_q;
            OFS_PEND: reg_rdata = pend_q;
            default:  reg_rdata = '0;
        endcase
    end

    dma_irq_evmap #(.GROUPS(GROUPS), .CPG(CH_PER_GRP), .DW(DATA_W)) u_evmap (
        .half_pulse (ch_half),
        .done_pulse (ch_done),
        .set_vec    (set_vec)
    );

    dma_irq_pend #(.DW(DATA_W)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .pend_q  (pend_q)
    );

    dma_irq_gen #(.DW(DATA_W)) u_gen (
        .clk   (clk),
        .rst_n (rst_n),
        .pend  (pend_q),
        .mask  (mask_q),
        .irq_q (irq)
    );

    // R8: a mask write is stored
    p_mask_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask |=> (mask_q == $past(reg_wdata)));
    // R9: writes elsewhere leave the mask alone
    p_stray_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !wr_mask) |=> $stable(mask_q));
    // R6: an event sets its bit regardless of the mask
    p_unmasked_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_done[0] && mask_q[1] == 1'b0) |=> pend_q[1]);
endmodule

// File: tb/dma_irq_agg_tb_top.sv
`timescale 1ns/1ps
module dma_irq_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] ch_half = '0;
    logic [15:0] ch_done = '0;
    logic        irq;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    dma_irq_agg dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ch_half(ch_half), .ch_done(ch_done), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one write cycle, returns at the following falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // one-cycle event pulses
    task automatic pulse(input logic [15:0] h, input logic [15:0] e);
        @(negedge clk);
        ch_half = h; ch_done = e;
        @(negedge clk);
        ch_half = '0; ch_done = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd(8'h00, v); chk("R1 mask", v, 32'h0);
        rd(8'h04, v); chk("R1 pend", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_map;
        logic [31:0] v;
        for (int g = 0; g < 2; g++) begin
            for (int i = 0; i < 8; i++) begin
                pulse(16'h1 << (g*8+i), 16'h0);
                rd(8'h04, v); chk("R2 half", v, 32'h1 << (g*16 + 2*i));
                wr(8'h04, 32'hFFFF_FFFF);
                pulse(16'h0, 16'h1 << (g*8+i));
                rd(8'h04, v); chk("R2 done", v, 32'h1 << (g*16 + 2*i + 1));
                chk("R2 done mask", v & 32'h5555_5555, 32'h0);
                wr(8'h04, 32'hFFFF_FFFF);
            end
        end
    endtask

    task automatic t_sticky_clear;
        logic [31:0] v;
        pulse(16'h0081, 16'h8100);
        repeat (4) @(negedge clk);
        rd(8'h04, v); chk("R3 sticky", v, 32'h8002_4001);
        wr(8'h04, 32'h0000_4001);
        rd(8'h04, v); chk("R4 partial clear", v, 32'h8002_0000);
        wr(8'h04, 32'hFFFF_FFFF);
        rd(8'h04, v); chk("R4 clear all", v, 32'h0);
    endtask

    task automatic t_collision;
        logic [31:0] v;
        pulse(16'h0000, 16'h0006);   // bits 3 and 5
        @(negedge clk);
        reg_addr = 8'h04; reg_wr = 1'b1; reg_wdata = 32'h0000_0028;
        ch_done = 16'h0002;          // bit 3 again, same edge
        @(negedge clk);
        reg_wr = 1'b0; ch_done = '0;
        rd(8'h04, v); chk("R5 set wins", v, 32'h0000_0008);
        wr(8'h04, 32'hFFFF_FFFF);
    endtask

    task automatic t_irq;
        logic [31:0] v;
        wr(8'h00, 32'h0);
        pulse(16'h0000, 16'h0100);   // channel 8 -> bit 17
        rd(8'h04, v); chk("R6 masked set", v, 32'h0002_0000);
        @(negedge clk);
        chk("R7 masked irq", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'h0002_0000);
        // mask stored at edge k; irq flop captures at edge k+1
        chk("R7 not yet", {31'b0, irq}, 32'h0);
        @(negedge clk);
        chk("R7 raised", {31'b0, irq}, 32'h1);
        wr(8'h04, 32'h0002_0000);
        @(negedge clk);
        chk("R7 dropped", {31'b0, irq}, 32'h0);
        wr(8'h00, 32'hA5C3_0F96);
        rd(8'h00, v); chk("R8 mask rw", v, 32'hA5C3_0F96);
        wr(8'h00, 32'h0);
    endtask

    task automatic t_stray;
        logic [31:0] v;
        wr(8'h00, 32'h0000_00FF);
        pulse(16'h0001, 16'h0000);
        wr(8'h08, 32'hFFFF_FFFF);
        wr(8'h40, 32'h0);
        rd(8'h00, v); chk("R9 mask kept", v, 32'h0000_00FF);
        rd(8'h04, v); chk("R9 pend kept", v, 32'h0000_0001);
        rd(8'h08, v); chk("R9 read zero", v, 32'h0);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h00, 32'h0);
    endtask

    initial begin
        t_reset();
        t_map();
        t_sticky_clear();
        t_collision();
        t_irq();
        t_stray();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule